// File: doc/BRIEF.md
# Register-Driven Management Bus Master

This block drives a two-wire management bus (a clock, MDC, and a bidirectional data line, MDIO, with an output enable) from two 32-bit registers. The control register sets the MDC half-period in system clocks and whether a run of ones precedes each frame. It also carries a sticky completion flag. Software packs a whole frame into one 32-bit word: start, read or write opcode, device address, register number, turnaround and 16 data bits. Writing that word to the data register sends it on the bus, most significant bit first.

For a read frame the master lets go of MDIO from the turnaround field onward. It samples the slave's 16 data bits on rising MDC edges. When the frame ends, the captured value replaces the low half of the data register. Software polls the completion flag and then reads the data register. Writing zero to the control register stops any frame and leaves the block idle.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset both register readbacks are zero and MDC, MDIO and the MDIO output enable are all low.
- R2: A control write stores the divisor from bits [6:0] and the preamble enable from bit 7. Readback shows the divisor in [6:0], the preamble enable in bit 7 and the completion flag in bit 8. Writing bit 8 has no effect, and the upper bits read as zero.
- R3: While a frame runs, each bit lasts 2×H system clocks: MDC is low for the first H clocks and high for the last H, where H is the divisor latched at launch. When no frame runs, MDC is low.
- R4: With the preamble enabled, 32 ones are driven on MDIO, with the output enable high, before the frame word.
- R5: The 32-bit word is driven MSB first. Each bit appears when MDC falls, and the first bit appears on the clock after the data write.
- R6: A read frame is one whose word has bit 29 set. For a read frame the output enable drops from word bit 17 onward. Word bits 15..0 are sampled from MDIO on rising MDC edges. At completion they land MSB first in data register bits [15:0], and bits [31:16] keep the written value. A write frame keeps the output enable high for the whole frame.
- R7: The completion flag (control bit 8) clears on the clock after a launch. It rises 2×H×N clocks after the launch edge, where N is 64 with the preamble and 32 without. It then stays set until the next launch or an abort.
- R8: A data write that arrives while a frame runs is ignored. The data register and the bus waveform continue unchanged.
- R9: A control write whose bits [7:0] are all zero ends any frame at once: MDC, MDIO and the output enable go low, and the completion flag clears.
- R10: The control value 0x82 (preamble on, divisor 2) produces a correct frame with a 4-clock MDC period.
- R11: A divisor of 0 behaves as a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the data register |
| wr_data | input | 32 | Write value |
| ctrl_rd | output | 32 | Control register readback |
| data_rd | output | 32 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the line |

## Verification
Register readbacks change on the clock after the write. The first frame bit and the cleared completion flag also appear one clock after the data write. An MDC edge shows H clocks after the start of its bit, and the completion flag with the captured read data shows exactly 2×H×N clocks after launch. The bench runs a behavioural model that advances a cycle count from the launch edge and derives the expected MDC level, bit value and output enable from that count alone. The model's slave drives MDIO for each read bit before the rising edge that samples it. All outputs are sampled on the falling system clock edge and compared on every cycle, so a bit that is early or late by one clock is caught.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  // control register fields
  localparam int DIV_W    = 7;
  localparam int PRE_BIT  = 7;
  localparam int DONE_BIT = 8;
  // data word fields used by the hardware
  localparam int RD_BIT   = 29;
  localparam int TA_BIT   = 17;
  localparam int WORD_W   = 32;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
endpackage

// File: rtl/mgmt_clk_tick.sv
module mgmt_clk_tick #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] half_in,
  input  logic             run,
  output logic             step
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= DIV_W'(1);
      ph     <= '0;
    end else if (load) begin
      half_q <= (half_in == '0) ? DIV_W'(1) : half_in;  // R11
      ph     <= '0;
    end else if (!run || step) begin
      ph <= '0;
    end else begin
      ph <= ph + DIV_W'(1);
    end
  end

  assign step = run && (ph == half_q - DIV_W'(1));

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (ph < half_q));
  p_half_nonzero_r11: assert property (@(posedge clk) disable iff (rst)
    half_q != '0);
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int PLEN  = PRE_LEN,
  parameter int DW    = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          abort,
  input  logic [W-1:0]  word,
  input  logic          pre_en,
  input  logic          step,
  input  logic          mdio_i,
  output logic          busy,
  output logic          fin,
  output logic          fin_rd,
  output logic [DW-1:0] rx_data,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int FRAME_W = PLEN + W;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int REL_OFS = W - 1 - TA_BIT;
  localparam int CAP_OFS = W - DW;

  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]   idx, base, nxt, rel_at, cap_at, last_idx;
  logic               busy_q, hi, mdc_q, o_q, oe_q, rd_q, pre_q;
  logic [DW-1:0]      rx_q;

  assign base     = pre_q ? IDX_W'(PLEN) : '0;
  assign nxt      = idx + IDX_W'(1);
  assign rel_at   = base + IDX_W'(REL_OFS);
  assign cap_at   = base + IDX_W'(CAP_OFS);
  assign last_idx = base + IDX_W'(W - 1);
  assign fin      = busy_q && step && hi && (idx == last_idx) && !abort;
  assign fin_rd   = fin && rd_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy_q <= 1'b0;
      hi     <= 1'b0;
      mdc_q  <= 1'b0;
      o_q    <= 1'b0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      pre_q  <= 1'b0;
      idx    <= '0;
      sh     <= '0;
      rx_q   <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      hi     <= 1'b0;
      mdc_q  <= 1'b0;
      idx    <= '0;
      rd_q   <= word[RD_BIT];
      pre_q  <= pre_en;
      sh     <= pre_en ? {{PLEN{1'b1}}, word} : {word, {PLEN{1'b0}}};
      o_q    <= pre_en ? 1'b1 : word[W-1];
      oe_q   <= 1'b1;
      rx_q   <= '0;
    end else if (busy_q && step) begin
      if (!hi) begin
        hi    <= 1'b1;
        mdc_q <= 1'b1;
        if (rd_q && idx >= cap_at) rx_q <= {rx_q[DW-2:0], mdio_i};
      end else if (idx == last_idx) begin
        busy_q <= 1'b0;
        hi     <= 1'b0;
        mdc_q  <= 1'b0;
        o_q    <= 1'b0;
        oe_q   <= 1'b0;
      end else begin
        hi    <= 1'b0;
        mdc_q <= 1'b0;
        idx   <= nxt;
        sh    <= sh << 1;
        o_q   <= sh[FRAME_W-2];
        oe_q  <= !(rd_q && nxt >= rel_at);
      end
    end
  end

  assign busy    = busy_q;
  assign rx_data = rx_q;
  assign mdc     = mdc_q;
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  p_mdc_toggles_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q && step && !abort |=> mdc_q != $past(mdc_q));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !mdc_q && !oe_q);
  p_preamble_ones_r4: assert property (@(posedge clk) disable iff (rst)
    busy_q && pre_q && (idx < IDX_W'(PLEN)) |-> o_q && oe_q);
  p_write_drives_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q && !rd_q |-> oe_q);
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int DW = DATA_W,
  parameter int DV = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          busy,
  input  logic          fin,
  input  logic          fin_rd,
  input  logic [DW-1:0] rx_data,
  output logic          launch,
  output logic          abort,
  output logic [DV-1:0] div,
  output logic          pre_en,
  output logic [W-1:0]  ctrl_rd,
  output logic [W-1:0]  data_rd
);
  logic [DV-1:0] div_q;
  logic          pre_q, done_q;
  logic [W-1:0]  data_q;

  assign launch = wr_en && wr_sel && !busy;
  assign abort  = wr_en && !wr_sel && (wr_data[PRE_BIT:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_en && !wr_sel) begin
        div_q <= wr_data[DV-1:0];
        pre_q <= wr_data[PRE_BIT];
      end
      if (abort || launch) done_q <= 1'b0;
      else if (fin)        done_q <= 1'b1;
      if (launch)      data_q            <= wr_data;
      else if (fin_rd) data_q[DW-1:0]    <= rx_data;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[DV-1:0]   = div_q;
    ctrl_rd[PRE_BIT]  = pre_q;
    ctrl_rd[DONE_BIT] = done_q;
  end

  assign data_rd = data_q;
  assign div     = div_q;
  assign pre_en  = pre_q;

  p_launch_clears_done_r7: assert property (@(posedge clk) disable iff (rst)
    launch |=> !done_q);
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_sel && busy && !fin |=> $stable(data_q));
  p_abort_idles_r9: assert property (@(posedge clk) disable iff (rst)
    abort |=> !done_q && div_q == '0 && !pre_q);
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int DW = DATA_W,
  parameter int DV = DIV_W,
  parameter int PL = PRE_LEN
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_rd,
  output logic [W-1:0] data_rd,
  output logic         mdc,
  output logic         mdio_o,
  output logic         mdio_oe,
  input  logic         mdio_i
);
  logic          launch, abort, busy, fin, fin_rd, step, pre_en;
  logic [DV-1:0] div;
  logic [DW-1:0] rx_data;

  mgmt_regs #(.W(W), .DW(DW), .DV(DV)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .fin(fin), .fin_rd(fin_rd), .rx_data(rx_data),
    .launch(launch), .abort(abort), .div(div), .pre_en(pre_en),
    .ctrl_rd(ctrl_rd), .data_rd(data_rd)
  );

  mgmt_clk_tick #(.DIV_W(DV)) u_tick (
    .clk(clk), .rst(rst), .load(launch), .half_in(div), .run(busy), .step(step)
  );

  mgmt_frame_engine #(.W(W), .PLEN(PL), .DW(DW)) u_engine (
    .clk(clk), .rst(rst), .launch(launch), .abort(abort), .word(wr_data),
    .pre_en(pre_en), .step(step), .mdio_i(mdio_i), .busy(busy), .fin(fin),
    .fin_rd(fin_rd), .rx_data(rx_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/mgmt_bus_master_test.sv
module mgmt_bus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_sel = 1'b0, mdio_i = 1'b1;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_rd, data_rd;
  logic mdc, mdio_o, mdio_oe;

  mgmt_bus_master uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .data_rd(data_rd), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic cmp_on = 1'b0;

  // behavioural reference model
  logic        m_busy = 0, m_done = 0, m_pre = 0, m_rd = 0, m_fpre = 0;
  logic [6:0]  m_div = 0;
  logic [31:0] m_word = 0, m_data = 0;
  logic [15:0] m_rx = 0, reply = 16'h0;
  int          m_t = 0, m_half = 1, m_n = 32, m_base = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int  k;
    logic pb;
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_pre = 0; m_div = 0; m_data = 0; m_rx = 0;
    end else begin
      pb = m_busy;
      if (m_busy) begin
        if (m_t % (2*m_half) == m_half - 1) begin
          k = m_t / (2*m_half);
          if (m_rd && k >= m_base + 16) m_rx = {m_rx[14:0], mdio_i};
        end
        m_t++;
        if (m_t == m_n*2*m_half) begin
          m_busy = 0; m_done = 1;
          if (m_rd) m_data[15:0] = m_rx;
        end
      end
      if (wr_en && !wr_sel) begin
        m_div = wr_data[6:0]; m_pre = wr_data[7];
        if (wr_data[7:0] == 8'h00) begin m_busy = 0; m_done = 0; end
      end else if (wr_en && wr_sel && !pb) begin
        m_busy = 1; m_done = 0; m_t = 0; m_word = wr_data; m_data = wr_data;
        m_half = (m_div == 0) ? 1 : int'(m_div);
        m_fpre = m_pre; m_n = m_pre ? 64 : 32; m_base = m_pre ? 32 : 0;
        m_rd = wr_data[29]; m_rx = 0;
      end
    end
    if (cyc == WATCHDOG) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual busy %0d expected idle", m_busy);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // every-cycle compare and slave drive, away from the active edge
  always @(negedge clk) begin
    int k, w, p;
    logic e_mdc, e_o, e_oe;
    if (cmp_on) begin
      e_mdc = 0; e_o = 0; e_oe = 0; p = -1;
      if (m_busy) begin
        k = m_t / (2*m_half); w = m_t % (2*m_half); p = k - m_base;
        e_mdc = (w >= m_half);
        e_o   = (k < m_base) ? 1'b1 : m_word[31-p];
        e_oe  = !(m_rd && p >= 14);
      end
      check({31'b0, mdc}, {31'b0, e_mdc}, "R3 mdc");
      check({31'b0, mdio_o}, {31'b0, e_o}, (m_busy && p < 0) ? "R4 preamble" : "R5 bit");
      check({31'b0, mdio_oe}, {31'b0, e_oe}, "R6 oe");
      check(ctrl_rd, {23'b0, m_done, m_pre, m_div}, "R2/R7 ctrl");
      check(data_rd, m_data, "R6/R8 data");
      if (m_busy && m_rd && p >= 16 && p < 32) mdio_i = reply[31-p];
      else mdio_i = 1'b1;
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] wword;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(ctrl_rd, 32'h0, "R1 ctrl");
    check(data_rd, 32'h0, "R1 data");
    check({29'b0, mdc, mdio_o, mdio_oe}, 32'h0, "R1 pins");
    cmp_on = 1;

    // R2: bit 8 is read-only, upper bits read zero; R10 setting
    wr(0, 32'hFFFF_FE82);
    check(ctrl_rd, 32'h0000_0082, "R2 ctrl readback");

    // R10/R4/R5/R7: write frame with preamble, divisor 2
    wword = 32'h5000_0000 | (32'h1F << 22) | (32'h3 << 18) | 32'h0002_BEEF;
    wr(1, wword);
    check(data_rd, wword, "R5 data latched");
    check(ctrl_rd[8], 1'b0, "R7 done clear after launch");
    idle(100);
    // R8: write while busy is ignored
    wr(1, 32'h6123_4567);
    check(data_rd, wword, "R8 data unchanged");
    wait_idle();
    check(ctrl_rd[8], 1'b1, "R7 done set");
    idle(5);
    check(ctrl_rd[8], 1'b1, "R7 done sticky");

    // R6: read frame, divisor 3, no preamble
    wr(0, 32'h0000_0003);
    reply = 16'hC3A5;
    wword = 32'h6000_0000 | (32'h0A << 22) | (32'h6 << 18) | 32'h0002_1111;
    wr(1, wword);
    wait_idle();
    check(data_rd, {wword[31:16], 16'hC3A5}, "R6 read capture");

    // R11: divisor 0 acts as 1, with preamble; another read pattern
    wr(0, 32'h0000_0080);
    reply = 16'h5A0F;
    wr(1, 32'h6000_0000 | (32'h01 << 22) | (32'h2 << 18) | 32'h0002_0000);
    wait_idle();
    check(data_rd[15:0], 16'h5A0F, "R11 read with div 0");

    // R9: abort mid-frame clears done and idles the bus
    wr(0, 32'h0000_0085);
    wr(1, 32'h5000_0000 | 32'h0002_00FF);
    idle(40);
    wr(0, 32'h0000_0000);
    check(ctrl_rd, 32'h0, "R9 ctrl after abort");
    check({30'b0, mdc, mdio_oe}, 32'h0, "R9 pins idle");
    idle(20);

    // R3/R5: short write frame without preamble, divisor 1
    wr(0, 32'h0000_0001);
    wr(1, 32'h5555_AAAA & 32'h5FFF_FFFF);
    wait_idle();
    check(ctrl_rd[8], 1'b1, "R3 done at divisor 1");
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule